// File: doc/BRIEF.md
# Burst Beat Address Sequencer

This block produces the address of each beat of a four-beat burst. On a load cycle it captures an external address and presents it as the first beat. On each advance cycle it moves to the next beat by changing only the two least significant address bits. The upper bits keep the loaded value for the whole burst.

A mode input picks one of two beat orderings. In interleaved order the beat bits are the starting bits XORed with the beat number. In linear order they are the starting bits plus the beat number, wrapping modulo four. An active-high suspend input freezes the block completely, and the other inputs are ignored while it is high. The output is registered, so the address for a cycle appears one clock after the control that selects it.

Top module: `abl_burst_seq`

## Requirements
- R1: While `rst` is high at a rising clock edge, `beat_addr` becomes 0 after that edge. The internal beat count and the stored start address also clear, so an advance right after reset walks the burst that starts at address 0.
- R2: A rising edge with `suspend`=0 and `step_nload`=0 is a load. After that edge `beat_addr` equals the `ext_addr` sampled at the edge.
- R3: When `interleave`=1, the low two bits after the k-th advance since the last load equal (start low bits) XOR (k mod 4). For example, a start of 1 gives 1,0,3,2. Every advance toggles bit 0 of `beat_addr`.
- R4: When `interleave`=0, the low two bits after the k-th advance since the last load equal (start low bits + k) mod 4. For example, a start of 1 gives 1,2,3,0.
- R5: An advance never changes `beat_addr[ADDR_W-1:2]`. A start address with upper bits all ones and low bits 3 does not carry.
- R6: A rising edge with `suspend`=1 leaves `beat_addr`, the beat count and the stored start address unchanged, whatever `step_nload`, `interleave` and `ext_addr` are. The next advance continues the same burst.
- R7: After the fourth beat, further advances keep cycling through the same four-address group.
- R8: A load in the middle of a burst sets the beat count back to zero. The following advances step from the new start address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| suspend | input | 1 | 1 freezes all state and ignores the other inputs |
| step_nload | input | 1 | 1 = advance to the next beat, 0 = load `ext_addr` |
| interleave | input | 1 | 1 = interleaved (XOR) order, 0 = linear (wrapping add) order |
| ext_addr | input | ADDR_W | Address captured on a load |
| beat_addr | output | ADDR_W | Registered address of the current beat |

## Verification
The hardest case to reach is a suspend that falls in the middle of a burst while every other input changes. While suspended, the stimulus drives a load strobe, a new external address and the opposite mode, then releases suspend and advances again. The burst must resume from the beat it held. The stimulus also starts bursts at each of the four low-bit values in both modes, runs past the fourth beat, uses an all-ones upper field to expose any carry, and reloads mid-burst. A behavioural model in the bench tracks start address and beat number as integers and is compared with the output on every clock.

// File: rtl/abl_pkg.sv
package abl_pkg;
  localparam int BEAT_W = 2;
  typedef logic [BEAT_W-1:0] beat_t;
endpackage

// File: rtl/abl_beat_ctr.sv
module abl_beat_ctr #(
  parameter int BW = abl_pkg::BEAT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          suspend,
  input  logic          step_nload,
  output logic [BW-1:0] cnt_q,
  output logic [BW-1:0] cnt_d
);
  logic do_load;
  logic do_step;

  assign do_load = !suspend && !step_nload;
  assign do_step = !suspend &&  step_nload;

  always_comb begin
    cnt_d = cnt_q;
    if (do_load)      cnt_d = '0;
    else if (do_step) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end
endmodule

// File: rtl/abl_order_map.sv
module abl_order_map #(
  parameter int BW = abl_pkg::BEAT_W
) (
  input  logic          interleave,
  input  logic [BW-1:0] start_lo,
  input  logic [BW-1:0] beat,
  output logic [BW-1:0] lo
);
  logic [BW-1:0] xor_lo;
  logic [BW-1:0] add_lo;

  assign xor_lo = start_lo ^ beat;
  assign add_lo = start_lo + beat;
  assign lo     = interleave ? xor_lo : add_lo;
endmodule

// File: rtl/abl_burst_seq.sv
module abl_burst_seq #(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              suspend,
  input  logic              step_nload,
  input  logic              interleave,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] beat_addr
);
  localparam int BW = abl_pkg::BEAT_W;

  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] base_d;
  logic [BW-1:0]     cnt_q;
  logic [BW-1:0]     cnt_d;
  logic [BW-1:0]     lo_d;

  always_comb begin
    base_d = base_q;
    if (!suspend && !step_nload) base_d = ext_addr;
  end

  abl_beat_ctr #(.BW(BW)) u_ctr (
    .clk        (clk),
    .rst        (rst),
    .suspend    (suspend),
    .step_nload (step_nload),
    .cnt_q      (cnt_q),
    .cnt_d      (cnt_d)
  );

  abl_order_map #(.BW(BW)) u_map (
    .interleave (interleave),
    .start_lo   (base_d[BW-1:0]),
    .beat       (cnt_d),
    .lo         (lo_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q    <= '0;
      beat_addr <= '0;
    end else if (!suspend) begin
      base_q    <= base_d;
      beat_addr <= {base_d[ADDR_W-1:BW], lo_d};
    end
  end
endmodule

// File: rtl/abl_burst_seq_chk.sv
module abl_burst_seq_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst,
  input logic              suspend,
  input logic              step_nload,
  input logic              interleave,
  input logic [ADDR_W-1:0] ext_addr,
  input logic [ADDR_W-1:0] beat_addr
);
  AST_RESET_ZERO: assert property (@(posedge clk) rst |=> beat_addr == '0); // R1

  AST_LOAD_PASS: assert property (@(posedge clk) disable iff (rst)
    (!suspend && !step_nload) |=> beat_addr == $past(ext_addr)); // R2

  AST_BIT0_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    (!suspend && step_nload) |=> beat_addr[0] != $past(beat_addr[0])); // R3

  AST_UPPER_KEEP: assert property (@(posedge clk) disable iff (rst)
    (!suspend && step_nload) |=> beat_addr[ADDR_W-1:2] == $past(beat_addr[ADDR_W-1:2])); // R5

  AST_SUSPEND_HOLD: assert property (@(posedge clk) disable iff (rst)
    suspend |=> $stable(beat_addr)); // R6

  wire unused_mode = interleave;
endmodule

bind abl_burst_seq abl_burst_seq_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_abl_burst_seq.sv
module tb_abl_burst_seq;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          suspend = 1'b0;
  logic          step_nload = 1'b0;
  logic          interleave = 1'b0;
  logic [AW-1:0] ext_addr = '0;
  logic [AW-1:0] beat_addr;

  int    n_cmp = 0;
  int    n_bad = 0;
  int    m_base = 0;
  int    m_beat = 0;
  int    m_exp = 0;
  bit    started = 0;
  bit    done = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  abl_burst_seq #(.ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .suspend(suspend), .step_nload(step_nload),
    .interleave(interleave), .ext_addr(ext_addr), .beat_addr(beat_addr)
  );

  // behavioural reference: start address and beat number as integers
  always @(posedge clk) begin
    int lo;
    if (rst) begin
      m_base = 0; m_beat = 0; m_exp = 0;
    end else if (!suspend) begin
      if (!step_nload) begin
        m_base = int'(ext_addr); m_beat = 0;
      end else begin
        m_beat = m_beat + 1;
      end
      if (interleave) lo = (m_base % 4) ^ (m_beat % 4);
      else            lo = (m_base + m_beat) % 4;
      m_exp = (m_base / 4) * 4 + lo;
    end
    started = 1;
  end

  always @(negedge clk) begin
    if (started && !done) begin
      n_cmp++;
      if (int'(beat_addr) != m_exp) begin
        n_bad++;
        $display("FAIL %s: beat_addr actual %h expected %h", cur_req, beat_addr, m_exp[AW-1:0]);
      end
    end
  end

  task automatic drive(input bit sus, input bit snl, input bit md, input logic [AW-1:0] a);
    @(negedge clk);
    suspend = sus; step_nload = snl; interleave = md; ext_addr = a;
  endtask

  task automatic burst(input bit md, input logic [AW-1:0] a, input int steps);
    drive(0, 0, md, a);
    for (int i = 0; i < steps; i++) drive(0, 1, md, ~a);
  endtask

  initial begin
    cur_req = "R1";
    repeat (3) @(negedge clk);
    @(negedge clk); rst = 1'b0; step_nload = 1'b1;
    repeat (3) @(negedge clk);
    cur_req = "R2";
    burst(1, 20'hABCDE, 0);
    burst(0, 20'h12345, 0);
    burst(1, 20'h00003, 0);
    cur_req = "R3";
    for (int s = 0; s < 4; s++) burst(1, 20'h5A5A0 | s, 4);
    cur_req = "R4";
    for (int s = 0; s < 4; s++) burst(0, 20'h3C3C0 | s, 4);
    cur_req = "R5";
    burst(0, 20'hFFFFF, 5);
    burst(1, 20'hFFFFF, 5);
    burst(0, 20'h7FFFE, 5);
    cur_req = "R7";
    burst(1, 20'h00101, 11);
    burst(0, 20'h00102, 11);
    cur_req = "R6";
    burst(0, 20'h44441, 1);
    drive(1, 0, 1, 20'h99999);
    drive(1, 1, 1, 20'h11111);
    drive(1, 0, 0, 20'h22222);
    for (int i = 0; i < 4; i++) drive(0, 1, 0, 20'h0);
    burst(1, 20'h88882, 2);
    drive(1, 1, 0, 20'h33333);
    drive(1, 0, 0, 20'h33333);
    for (int i = 0; i < 3; i++) drive(0, 1, 1, 20'h0);
    cur_req = "R8";
    burst(0, 20'h66661, 2);
    burst(0, 20'h77772, 3);
    burst(1, 20'h55553, 1);
    burst(1, 20'h55551, 5);
    cur_req = "R2";
    for (int i = 0; i < 200; i++) begin
      logic [AW-1:0] a;
      a = AW'((i * 40503 + 17) % (1 << AW));
      drive((i % 7) == 3, (i % 5) != 0, (i % 11) < 6, a);
    end
    drive(0, 1, 0, 20'h0);
    @(negedge clk);
    cur_req = "R1";
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0; step_nload = 1'b1; interleave = 1'b0;
    repeat (3) @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule